// File: doc/BRIEF.md
# No-Turnaround Synchronous SRAM Core

This block is a reduced-depth, synthesizable model of a synchronous static RAM that never needs a dead cycle between a read and a write. Write data trails its address by one or two clock edges, and read data leaves with a matching delay. As a result, a read, a write and another read can be issued on three consecutive edges and all of them complete. A static mode pin selects between two timings. In registered-output mode, read data passes through an output register and write data comes two edges after its address. In flow-through mode, read data is driven straight from the array and write data comes one edge after its address.

Each command is either a load, which starts a new access at a new address, or an advance, which moves to the next beat of a four-beat burst. A second static pin selects linear or interleaved beat order. Three chip selects must all be high on a load for the access to happen. A byte-lane mask controls which 9-bit lanes a write changes. The output-enable pin and the sleep pin act on the data-out enable at once, with no clock edge needed. While sleep is high, commands are ignored and the array keeps its contents. A read that follows a pending late write to the same word returns the merged new data. The data bus is split into `wdata`, `rdata` and `rdata_oe`, so it can be joined to a pad ring.

Top module: `nbt_sram_core`

## Requirements
- R1: A load (`adv_ld`=0) starts an access only when `cs_a`, `cs_b` and `cs_c` are all 1. Otherwise that edge is a deselect: no write takes place and no read data is driven.
- R2: A read loaded at edge n drives `rdata_oe`=1 with the word during the cycle after edge n+1 in registered mode (`pipe_mode`=1). In flow-through mode (`pipe_mode`=0), it does so during the cycle after edge n.
- R3: The write data for a write loaded at edge n is sampled from `wdata` at edge n+2 in registered mode and at edge n+1 in flow-through mode.
- R4: `byte_wen` is sampled with each write command. Bit i enables `wdata[9i+8:9i]`, and lanes whose bit is 0 keep their old value.
- R5: An advance (`adv_ld`=1) during an active access goes to the next beat, with beat k = 0..3 repeating. Beat k uses the address with its two low bits replaced by `(a+k) mod 4` when `burst_il`=0, or by `a XOR k` when `burst_il`=1. The upper bits stay the same. An advance keeps the read or write type, ignores the chip selects, and after a deselect it stays a deselect.
- R6: Reads and writes alternated on consecutive edges, in any mix, all complete correctly with no idle edge between them.
- R7: A read issued one or two edges after a write to the same word returns the written lanes merged over the old contents.
- R8: When `oe`=0, `rdata_oe` is 0 and `rdata` is all zeros immediately, whatever the pipeline holds.
- R9: While `sleep`=1, `rdata_oe` is 0 and no command is accepted. Commands are also ignored on the two edges after `sleep` falls. Array contents are kept through sleep.
- R10: While `rst_n`=0, `rdata_oe` is 0 and `rdata` is zero. Reset drops commands in flight but does not clear the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline |
| pipe_mode | input | 1 | Static: 1 = registered output, 0 = flow-through |
| burst_il | input | 1 | Static: 1 = interleaved beat order, 0 = linear |
| sleep | input | 1 | Power-down request, blocks commands and disables output |
| cs_a | input | 1 | Chip select, active high |
| cs_b | input | 1 | Chip select, active high |
| cs_c | input | 1 | Chip select, active high |
| adv_ld | input | 1 | 0 = load a new address, 1 = advance the burst |
| wr_en | input | 1 | On a load: 1 = write, 0 = read |
| byte_wen | input | NB | Per-lane write enable |
| addr | input | AW | Word address |
| wdata | input | NB*BW | Late write data |
| oe | input | 1 | Asynchronous output enable |
| rdata | output | NB*BW | Read data, zero when not driven |
| rdata_oe | output | 1 | Data-out driver enable |

## Verification
The bench runs a reference model alongside the design and compares the output pair every clock. It fills the array, then drives single reads and writes, linear and interleaved bursts, strict read/write alternation, and write-then-read pairs on the same word at gaps of one and two edges. These patterns separate the two latencies, the beat order and the forwarding path. Random traffic with masked chip selects, a toggling output enable and sleep pulses then checks that deselects, asynchronous gating and the wake delay leave neither stray writes nor driven outputs. The whole sequence is repeated in flow-through mode after a reset, and a full readback confirms the contents were retained.

// File: rtl/nbt_pkg.sv
package nbt_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // low two address bits of a burst beat
  function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic       il);
    return il ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/nbt_sleep_gate.sv
module nbt_sleep_gate #(
  parameter int WAKE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep,
  output logic accept
);
  localparam int CW = $clog2(WAKE + 1);

  logic [CW-1:0] wake_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               wake_cnt <= '0;
    else if (sleep)           wake_cnt <= CW'(WAKE);
    else if (wake_cnt != '0)  wake_cnt <= wake_cnt - CW'(1);
  end

  assign accept = !sleep && (wake_cnt == '0);
endmodule

// File: rtl/nbt_cmd_decode.sv
module nbt_cmd_decode import nbt_pkg::*; #(
  parameter int AW = 6,
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          burst_il,
  input  logic          adv_ld,
  input  logic          wr_en,
  input  logic          sel_all,
  input  logic [NB-1:0] byte_wen,
  input  logic [AW-1:0] addr,
  output op_e           cmd_op,
  output logic [AW-1:0] cmd_addr,
  output logic [NB-1:0] cmd_be
);
  logic [AW-1:0] base;
  logic [1:0]    beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_op <= OP_IDLE;
      base   <= '0;
      beat   <= '0;
      cmd_be <= '0;
    end else if (!accept) begin
      cmd_op <= OP_IDLE;
    end else if (!adv_ld) begin
      if (sel_all) begin
        cmd_op <= wr_en ? OP_WRITE : OP_READ;
        base   <= addr;
        beat   <= '0;
        cmd_be <= byte_wen;
      end else begin
        cmd_op <= OP_IDLE;
      end
    end else if (cmd_op != OP_IDLE) begin
      beat   <= beat + 2'd1;
      cmd_be <= byte_wen;
    end
  end

  assign cmd_addr = {base[AW-1:2], burst_lo(base[1:0], beat, burst_il)};
endmodule

// File: rtl/nbt_data_path.sv
module nbt_data_path import nbt_pkg::*; #(
  parameter int AW = 6,
  parameter int NB = 2,
  parameter int BW = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pipe_mode,
  input  op_e              s1_op,
  input  logic [AW-1:0]    s1_addr,
  input  logic [NB-1:0]    s1_be,
  input  logic [NB*BW-1:0] wdata,
  output logic [NB*BW-1:0] rd_word,
  output logic             rd_live
);
  localparam int DW    = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  op_e           s2_op;
  logic [AW-1:0] s2_addr;
  logic [NB-1:0] s2_be;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s2_op <= OP_IDLE;
    else        s2_op <= s1_op;
  end

  always_ff @(posedge clk) begin
    s2_addr <= s1_addr;
    s2_be   <= s1_be;
  end

  // commit point: second stage when registered, first stage when flow-through
  logic          cm_en;
  logic [AW-1:0] cm_addr;
  logic [NB-1:0] cm_be;

  always_comb begin
    if (pipe_mode) begin
      cm_en   = (s2_op == OP_WRITE);
      cm_addr = s2_addr;
      cm_be   = s2_be;
    end else begin
      cm_en   = (s1_op == OP_WRITE);
      cm_addr = s1_addr;
      cm_be   = s1_be;
    end
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < NB; l++) begin
      if (cm_en && cm_be[l]) mem[cm_addr][l*BW +: BW] <= wdata[l*BW +: BW];
    end
  end

  logic [DW-1:0] arr_word;
  logic [DW-1:0] fwd_word;
  logic          fwd_hit;

  assign arr_word = mem[s1_addr];
  assign fwd_hit  = pipe_mode && (s2_op == OP_WRITE) && (s2_addr == s1_addr);

  // per-lane bypass of the write landing on the same edge
  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign fwd_word[g*BW +: BW] = (fwd_hit && s2_be[g]) ? wdata[g*BW +: BW]
                                                         : arr_word[g*BW +: BW];
  end

  logic [DW-1:0] rd_q;
  logic          rd_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_v <= 1'b0;
    else        rd_v <= (s1_op == OP_READ);
  end

  always_ff @(posedge clk) rd_q <= fwd_word;

  assign rd_word = pipe_mode ? rd_q : arr_word;
  assign rd_live = pipe_mode ? rd_v : (s1_op == OP_READ);
endmodule

// File: rtl/nbt_sram_core.sv
module nbt_sram_core import nbt_pkg::*; #(
  parameter int AW   = 6,
  parameter int NB   = 2,
  parameter int BW   = 9,
  parameter int WAKE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pipe_mode,
  input  logic             burst_il,
  input  logic             sleep,
  input  logic             cs_a,
  input  logic             cs_b,
  input  logic             cs_c,
  input  logic             adv_ld,
  input  logic             wr_en,
  input  logic [NB-1:0]    byte_wen,
  input  logic [AW-1:0]    addr,
  input  logic [NB*BW-1:0] wdata,
  input  logic             oe,
  output logic [NB*BW-1:0] rdata,
  output logic             rdata_oe
);
  localparam int DW = NB * BW;

  logic          accept;
  op_e           s1_op;
  logic [AW-1:0] s1_addr;
  logic [NB-1:0] s1_be;
  logic [DW-1:0] rd_word;
  logic          rd_live;

  nbt_sleep_gate #(.WAKE(WAKE)) u_gate (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .accept(accept)
  );

  nbt_cmd_decode #(.AW(AW), .NB(NB)) u_cmd (
    .clk(clk), .rst_n(rst_n), .accept(accept), .burst_il(burst_il),
    .adv_ld(adv_ld), .wr_en(wr_en), .sel_all(cs_a && cs_b && cs_c),
    .byte_wen(byte_wen), .addr(addr),
    .cmd_op(s1_op), .cmd_addr(s1_addr), .cmd_be(s1_be)
  );

  nbt_data_path #(.AW(AW), .NB(NB), .BW(BW)) u_dp (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode),
    .s1_op(s1_op), .s1_addr(s1_addr), .s1_be(s1_be), .wdata(wdata),
    .rd_word(rd_word), .rd_live(rd_live)
  );

  assign rdata_oe = rd_live && oe && !sleep;
  assign rdata    = rdata_oe ? rd_word : '0;
endmodule

// File: rtl/nbt_sram_chk.sv
module nbt_sram_chk import nbt_pkg::*; #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pipe_mode,
  input logic          sleep,
  input logic          adv_ld,
  input logic          cs_a,
  input logic          cs_b,
  input logic          cs_c,
  input logic          accept,
  input logic          rd_live,
  input op_e           s1_op,
  input logic [AW-1:0] s1_addr
);
  assert_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_ld && accept && !(cs_a && cs_b && cs_c)) |=> (s1_op == OP_IDLE));

  assert_pipe_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && rd_live) |-> ($past(s1_op) == OP_READ));

  assert_adv_after_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_ld && s1_op == OP_IDLE) |=> (s1_op == OP_IDLE));

  assert_adv_upper_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_ld && accept && s1_op != OP_IDLE) |=> (s1_addr[AW-1:2] == $past(s1_addr[AW-1:2])));

  assert_sleep_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (s1_op == OP_IDLE));

  assert_wake_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sleep) && !sleep) |=> (s1_op == OP_IDLE));
endmodule

bind nbt_sram_core nbt_sram_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .sleep(sleep),
  .adv_ld(adv_ld), .cs_a(cs_a), .cs_b(cs_b), .cs_c(cs_c),
  .accept(accept), .rd_live(rd_live), .s1_op(s1_op), .s1_addr(s1_addr)
);

// File: tb/nbt_sram_core_tb.sv
module nbt_sram_core_tb;
  localparam int AW = 6;
  localparam int NB = 2;
  localparam int BW = 9;
  localparam int DW = NB * BW;
  localparam int T  = 20;

  logic clk = 1'b0;
  always #(T/2) clk = ~clk;

  logic rst_n = 1'b0, pipe_mode = 1'b1, burst_il = 1'b0, sleep = 1'b0;
  logic cs_a = 1'b0, cs_b = 1'b0, cs_c = 1'b0, adv_ld = 1'b0, wr_en = 1'b0;
  logic [NB-1:0] byte_wen = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic oe = 1'b1;
  logic [DW-1:0] rdata;
  logic rdata_oe;

  nbt_sram_core #(.AW(AW), .NB(NB), .BW(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .burst_il(burst_il),
    .sleep(sleep), .cs_a(cs_a), .cs_b(cs_b), .cs_c(cs_c), .adv_ld(adv_ld),
    .wr_en(wr_en), .byte_wen(byte_wen), .addr(addr), .wdata(wdata), .oe(oe),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  int n_chk = 0, n_err = 0;
  string tag = "R10";
  logic oe_v = 1'b1, slp_v = 1'b0;

  // ---------------- reference model ----------------
  typedef struct { logic [AW-1:0] a; logic [NB-1:0] be; int due; } wr_t;
  typedef struct { logic [AW-1:0] a; int due; } rd_t;

  logic [DW-1:0] m_mem [1 << AW];
  wr_t wq[$];
  rd_t rq[$];
  int  cyc = 0, b_op = 0, scnt = 0;
  logic [AW-1:0] b_base = '0, m_ea;
  logic [1:0]    b_beat = '0, m_lo;
  logic          m_acc, exp_en = 1'b0;
  logic [DW-1:0] exp_data = '0;

  initial for (int i = 0; i < (1 << AW); i++) m_mem[i] = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      wq.delete(); rq.delete();
      b_op = 0; scnt = 0; exp_en = 1'b0; cyc = 0;
    end else begin
      cyc++;
      while (wq.size() > 0 && wq[0].due == cyc) begin
        for (int l = 0; l < NB; l++)
          if (wq[0].be[l]) m_mem[wq[0].a][l*BW +: BW] = wdata[l*BW +: BW];
        void'(wq.pop_front());
      end
      m_acc = !sleep && scnt == 0;
      scnt  = sleep ? 2 : (scnt > 0 ? scnt - 1 : 0);
      if (!m_acc) b_op = 0;
      else if (!adv_ld) begin
        if (cs_a && cs_b && cs_c) begin
          b_op = wr_en ? 2 : 1; b_base = addr; b_beat = 2'd0;
        end else b_op = 0;
      end else if (b_op != 0) b_beat = b_beat + 2'd1;
      if (b_op != 0) begin
        m_lo = burst_il ? (b_base[1:0] ^ b_beat) : (b_base[1:0] + b_beat);
        m_ea = {b_base[AW-1:2], m_lo};
        if (b_op == 2) wq.push_back('{m_ea, byte_wen, cyc + (pipe_mode ? 2 : 1)});
        else           rq.push_back('{m_ea, cyc + (pipe_mode ? 1 : 0)});
      end
      exp_en = 1'b0;
      if (rq.size() > 0 && rq[0].due == cyc) begin
        exp_en = 1'b1; exp_data = m_mem[rq[0].a]; void'(rq.pop_front());
      end
    end
  end

  // ---------------- per-clock comparison ----------------
  always @(posedge clk) begin
    logic e_oe;
    logic [DW-1:0] e_d;
    #(T/4);
    if (rst_n) begin
      e_oe = exp_en && oe && !sleep;
      e_d  = e_oe ? exp_data : '0;
      n_chk++;
      if (rdata_oe !== e_oe || rdata !== e_d) begin
        n_err++;
        $display("FAIL %s: actual oe=%0b data=%h expected oe=%0b data=%h",
                 tag, rdata_oe, rdata, e_oe, e_d);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input logic adv, input logic wr, input logic [2:0] ce,
                      input logic [NB-1:0] be, input logic [AW-1:0] a);
    @(negedge clk);
    adv_ld = adv; wr_en = wr; {cs_a, cs_b, cs_c} = ce;
    byte_wen = be; addr = a; wdata = DW'($urandom);
    oe = oe_v; sleep = slp_v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 3'b000, '0, '0);
  endtask

  task automatic traffic(input int n, input bit v_ce, input bit v_oe, input bit v_slp);
    for (int i = 0; i < n; i++) begin
      oe_v  = v_oe  ? ($urandom % 4 != 0) : 1'b1;
      slp_v = v_slp ? ($urandom % 12 == 0) : 1'b0;
      step(($urandom % 4 == 0), $urandom % 2,
           (v_ce && $urandom % 3 == 0) ? 3'($urandom) : 3'b111,
           NB'($urandom), AW'($urandom));
    end
    oe_v = 1'b1; slp_v = 1'b0;
  endtask

  task automatic readback();
    for (int a = 0; a < (1 << AW); a++) step(1'b0, 1'b0, 3'b111, '0, AW'(a));
    idle(3);
  endtask

  task automatic run_mode();
    tag = "R5";
    step(1'b0, 1'b1, 3'b111, '1, 6);                       // linear write from 6
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 3'b000, '1, '0);
    step(1'b0, 1'b0, 3'b111, '0, 5);                       // linear read from 5, wraps
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 3'b010, '0, '0);
    idle(2); step(1'b1, 1'b0, 3'b111, '0, 9); idle(2);    // advance after deselect
    burst_il = 1'b1;
    step(1'b0, 1'b1, 3'b111, 2'b01, 14);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 3'b111, 2'b10, '0);
    step(1'b0, 1'b0, 3'b111, '0, 13);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 3'b111, '0, '0);
    idle(3); burst_il = 1'b0;
    tag = "R6";
    for (int i = 0; i < 24; i++) step(1'b0, i % 2, 3'b111, '1, AW'($urandom % 8));
    idle(3);
    tag = "R7";
    step(1'b0, 1'b1, 3'b111, 2'b01, 12); step(1'b0, 1'b0, 3'b111, '0, 12);
    step(1'b0, 1'b1, 3'b111, 2'b10, 20); idle(1); step(1'b0, 1'b0, 3'b111, '0, 20);
    for (int i = 0; i < 16; i++) begin
      logic [AW-1:0] a = AW'($urandom);
      step(1'b0, 1'b1, 3'b111, NB'($urandom), a);
      if (i % 2) idle(1);
      step(1'b0, 1'b0, 3'b111, '0, a);
    end
    idle(3);
    tag = "R4"; traffic(60, 0, 0, 0); idle(3);
    tag = "R1"; traffic(80, 1, 0, 0); idle(3);
    tag = "R8"; traffic(80, 0, 1, 0); idle(3);
    tag = "R9"; traffic(120, 1, 1, 1); idle(3);
    slp_v = 1'b1; traffic(0, 0, 0, 0);
    slp_v = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 3'b111, '1, AW'(i));
    slp_v = 1'b0;
    step(1'b0, 1'b1, 3'b111, '1, 3); step(1'b0, 1'b1, 3'b111, '1, 4);
    step(1'b0, 1'b0, 3'b111, '0, 0);
    idle(3);
    readback();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;                                               // R10 reset state
    if (rdata_oe !== 1'b0 || rdata !== '0) begin
      n_err++;
      $display("FAIL R10: actual oe=%0b data=%h expected oe=0 data=0", rdata_oe, rdata);
    end
    rst_n = 1'b1;
    tag = "R3";
    for (int a = 0; a < (1 << AW); a++) step(1'b0, 1'b1, 3'b111, '1, AW'(a));
    idle(3);
    tag = "R2"; readback();
    run_mode();
    // flow-through pass: mode changes only under reset
    idle(3);
    @(negedge clk); rst_n = 1'b0; pipe_mode = 1'b0;
    repeat (2) @(negedge clk);
    n_chk++;                                               // R10 reset again
    if (rdata_oe !== 1'b0) begin
      n_err++;
      $display("FAIL R10: actual oe=%0b expected oe=0", rdata_oe);
    end
    rst_n = 1'b1;
    tag = "R10"; readback();                               // array kept across reset
    tag = "R2"; traffic(40, 0, 0, 0); idle(3);
    run_mode();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(T * 200000);
    n_err++;
    $display("FAIL watchdog (%s): actual=running expected=finished", tag);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule